// File: doc/BRIEF.md
# Internal Oscillator Clock Switcher

This block picks the system clock from a family of on-chip oscillators and moves between them without producing a runt pulse. One fast input is divided down into seven rates, from the full input rate down to one sixty-fourth of it. A separate low-power oscillator supplies the slowest setting. A 3-bit select input may change at any time. The block turns each oscillator on and off through an enable output. Before it hands the clock over to an oscillator it has just started, it waits a programmable settling time. Two ready flags report which oscillator is settled.

A handover always goes the same way. The clock currently in use is gated off at one of its own falling edges, and the output then stays low. The new clock is gated on at one of its own falling edges, but only after the old gate is seen closed. When the new source is confirmed, the matching ready flag is updated. The settling wait counts cycles of a free-running reference clock, and it is applied only when the handover crosses between the two oscillators. Two keep-alive inputs (watchdog and fail-safe monitor) hold the low-power oscillator running. While either is high, that oscillator needs no settling wait.

Top module: `osc_clk_switch`

## Requirements
- R1: Select code 0 drives `sys_clk` from `lf_clk`. A code c from 1 to 7 drives it with a period of 2^(7-c) periods of `hf_clk`: code 7 is `hf_clk` itself and code 1 is `hf_clk`/64.
- R2: After reset the block runs from code `RST_CODE` (default 6) with `hf_ready`=1, `hf_osc_en`=1 and `lf_ready`=0, and `lf_osc_en` equals the OR of the keep-alive inputs.
- R3: No high or low phase of `sys_clk` is shorter than half an `hf_clk` period, and at most one source gate is open at any time.
- R4: On a change from code 0 to a nonzero code, `hf_osc_en` rises at once. `sys_clk` keeps the low-power rate, and `hf_ready` rises only after at least `STABLE_CYC` reference cycles.
- R5: Once a switch to a nonzero code completes with both keep-alive inputs low, `lf_osc_en`=0 and `lf_ready`=0.
- R6: On a change from a nonzero code to 0, `lf_ready` rises no earlier than `STABLE_CYC` reference cycles later when both keep-alive inputs are low. It rises in fewer than `STABLE_CYC` cycles when either keep-alive input is high.
- R7: Once a switch to code 0 completes, `hf_osc_en`=0, `hf_ready`=0 and `lf_ready`=1.
- R8: A change between two nonzero codes applies no settling wait. `hf_ready` and `hf_osc_en` stay 1 throughout, and between codes 4 to 7 the new rate is reached in fewer than `STABLE_CYC` cycles.
- R9: A select change that arrives during a handover is held, and the output ends at the rate of the last select value.
- R10: While either keep-alive input is high, `lf_osc_en`=1, and `lf_ready` stays 1 after a move from code 0 to a fast code. When both keep-alive inputs fall while a fast code is active, `lf_osc_en` and `lf_ready` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for control and settling count |
| hf_clk | input | 1 | Fast oscillator clock (top rate) |
| lf_clk | input | 1 | Low-power oscillator clock |
| rst_n | input | 1 | Active-low reset |
| sel_in | input | SEL_W | Requested rate code, asynchronous |
| keep_wdt | input | 1 | Watchdog needs the low-power oscillator |
| keep_mon | input | 1 | Fail-safe monitor needs the low-power oscillator |
| sys_clk | output | 1 | Selected system clock |
| hf_osc_en | output | 1 | Enable for the fast oscillator |
| lf_osc_en | output | 1 | Enable for the low-power oscillator |
| hf_ready | output | 1 | Fast oscillator settled and in use or available |
| lf_ready | output | 1 | Low-power oscillator settled |

## Verification
If the control state lost track of the active source, the next handover would show it at once. Either `sys_clk` would settle at the wrong period within a few source periods, or two gates would open together and produce a short phase on the output. A wrong settling count shows as a ready flag that rises sooner than `STABLE_CYC` reference cycles after the enable, or never rises. Flag bookkeeping errors show as an enable or ready level that disagrees with the active code a few reference cycles after each handover.

// File: rtl/osc_sw_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the oscillator clock switcher.
// Assumes: nothing beyond IEEE 1800-2017.
package osc_sw_pkg;

    // Control sequencer phases
    typedef enum logic [1:0] {
        SW_RUN  = 2'd0,   // steady, watching the select
        SW_WARM = 2'd1,   // counting the settling time of a started source
        SW_SWAP = 2'd2    // waiting for the gate handover to be confirmed
    } sw_state_e;

endpackage

// File: rtl/osc_sync.sv
`timescale 1ns/1ps
// Module: osc_sync
// Multi-stage synchronizer bringing an asynchronous vector into the clock
// domain of clk. Assumes each bit may be sampled independently (levels or
// Gray-like changes); RST_VAL sets the value seen during and after reset.
module osc_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/osc_div_chain.sv
`timescale 1ns/1ps
// Module: osc_div_chain
// Divide-by-two chain on the fast oscillator: bit k of the output toggles
// at hf_clk / 2^(k+1). Assumes hf_clk runs while rst_n is low so the
// synchronous reset takes effect.
module osc_div_chain #(
    parameter int TAPS = 6
) (
    input  logic            hf_clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] taps
);

    // Binary count: each bit halves the rate of the one below it
    always_ff @(posedge hf_clk) begin
        if (!rst_n) taps <= '0;
        else        taps <= taps + 1'b1;
    end

endmodule

// File: rtl/osc_gate_cell.sv
`timescale 1ns/1ps
// Module: osc_gate_cell
// Glitch-free gate for one clock source. The enable is retimed on falling
// edges of the source itself, so it only changes while the source is low.
// It opens only when no other gate is open. Assumes the source may be
// stopped during reset, so this cell alone uses an asynchronous clear.
module osc_gate_cell #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    input  logic others_on,
    output logic gate_on,
    output logic clk_out
);

    logic [STAGES-1:0] pipe;

    // Retime the open request into this source's domain on falling edges
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], req & ~others_on};
    end

    assign gate_on = pipe[STAGES-1];
    assign clk_out = clk_src & gate_on;

endmodule

// File: rtl/osc_sw_ctrl.sv
`timescale 1ns/1ps
// Module: osc_sw_ctrl
// Reference-clock sequencer. It watches the synchronized select, starts the
// oscillator that is needed, counts the settling time, moves the gate
// request and waits until the open gates confirm the handover. Then it
// updates the ready flags and powers down the unused oscillator.
// Assumes ref_clk runs at all times.
module osc_sw_ctrl
    import osc_sw_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int NSRC        = 8,
    parameter int STABLE_CYC  = 500,
    parameter int RST_CODE    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             keep_wdt,
    input  logic             keep_mon,
    input  logic [NSRC-1:0]  gate_on,
    output logic [NSRC-1:0]  req_vec,
    output logic             hf_osc_en,
    output logic             lf_osc_en,
    output logic             hf_ready,
    output logic             lf_ready
);

    localparam int               CNT_W  = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LST = CNT_W'(STABLE_CYC - 1);
    localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(RST_CODE);
    localparam logic             RST_NZ  = (RST_CODE != 0);

    logic [SEL_W-1:0] sel_s;
    logic [1:0]       keep_s;
    logic [NSRC-1:0]  ack_s;
    logic             keep;

    osc_sync #(.W(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL(RST_SEL)) u_sel_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(sel_in), .q(sel_s));
    osc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_keep_sync (
        .clk(ref_clk), .rst_n(rst_n), .d({keep_mon, keep_wdt}), .q(keep_s));
    osc_sync #(.W(NSRC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ack_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(gate_on), .q(ack_s));

    assign keep = |keep_s;

    sw_state_e        state;
    logic [SEL_W-1:0] cur_code;
    logic [SEL_W-1:0] tgt_code;
    logic [CNT_W-1:0] warm_cnt;
    logic             hf_en_q;
    logic             lf_en_q;
    logic             hf_rdy_q;
    logic             lf_rdy_q;
    logic             from_lf;
    logic [NSRC-1:0]  cur_mask;
    logic             swap_done;

    assign cur_mask  = NSRC'(1) << cur_code;
    assign swap_done = ack_s[cur_code] && ((ack_s & ~cur_mask) == '0);

    // Sequence oscillator start, settling count, handover and flag updates
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state    <= SW_RUN;
            cur_code <= RST_SEL;
            tgt_code <= RST_SEL;
            warm_cnt <= '0;
            hf_en_q  <= RST_NZ;
            lf_en_q  <= !RST_NZ;
            hf_rdy_q <= RST_NZ;
            lf_rdy_q <= !RST_NZ;
            from_lf  <= 1'b0;
        end else begin
            if (!lf_en_q && !keep) lf_rdy_q <= 1'b0;
            unique case (state)
                SW_RUN: begin
                    if (sel_s != cur_code) begin
                        tgt_code <= sel_s;
                        warm_cnt <= '0;
                        if (cur_code != '0 && sel_s != '0) begin
                            cur_code <= sel_s;
                            from_lf  <= 1'b0;
                            state    <= SW_SWAP;
                        end else if (cur_code == '0) begin
                            hf_en_q  <= 1'b1;
                            from_lf  <= 1'b1;
                            state    <= SW_WARM;
                        end else begin
                            lf_en_q  <= 1'b1;
                            from_lf  <= 1'b0;
                            if (keep) begin
                                cur_code <= '0;
                                state    <= SW_SWAP;
                            end else begin
                                state    <= SW_WARM;
                            end
                        end
                    end
                end
                SW_WARM: begin
                    if (warm_cnt == CNT_LST) begin
                        cur_code <= tgt_code;
                        state    <= SW_SWAP;
                    end else begin
                        warm_cnt <= warm_cnt + 1'b1;
                    end
                end
                SW_SWAP: begin
                    if (swap_done) begin
                        state <= SW_RUN;
                        if (cur_code == '0) begin
                            lf_rdy_q <= 1'b1;
                            hf_en_q  <= 1'b0;
                            hf_rdy_q <= 1'b0;
                        end else begin
                            hf_rdy_q <= 1'b1;
                            if (from_lf) begin
                                lf_en_q <= 1'b0;
                                if (!keep) lf_rdy_q <= 1'b0;
                            end
                        end
                    end
                end
                default: state <= SW_RUN;
            endcase
        end
    end

    assign req_vec   = cur_mask;
    assign hf_osc_en = hf_en_q;
    assign lf_osc_en = lf_en_q | keep;
    assign hf_ready  = hf_rdy_q;
    assign lf_ready  = lf_rdy_q & lf_osc_en;

endmodule

// File: rtl/osc_clk_switch.sv
`timescale 1ns/1ps
// Module: osc_clk_switch (top)
// Glitch-free selection of the system clock among the low-power source
// (code 0), the fast source (top code) and its divided rates (codes in
// between). Assumes ref_clk is free-running and both oscillator inputs
// toggle whenever their enables are high.
module osc_clk_switch #(
    parameter int SEL_W       = 3,
    parameter int STABLE_CYC  = 500,
    parameter int RST_CODE    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             hf_clk,
    input  logic             lf_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             keep_wdt,
    input  logic             keep_mon,
    output logic             sys_clk,
    output logic             hf_osc_en,
    output logic             lf_osc_en,
    output logic             hf_ready,
    output logic             lf_ready
);

    localparam int NSRC = 1 << SEL_W;
    localparam int TAPS = NSRC - 2;

    logic [TAPS-1:0] taps;
    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] req_vec;
    logic [NSRC-1:0] gate_on;
    logic [NSRC-1:0] others_on;
    logic [NSRC-1:0] clk_part;

    osc_div_chain #(.TAPS(TAPS)) u_div (
        .hf_clk(hf_clk), .rst_n(rst_n), .taps(taps));

    // One source and one gate cell per select code
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [NSRC-1:0] OTHER_MASK = ~(NSRC'(1) << i);
        if (i == 0) begin : g_lf
            assign src_clk[i] = lf_clk;
        end else if (i == NSRC - 1) begin : g_hf
            assign src_clk[i] = hf_clk;
        end else begin : g_div
            assign src_clk[i] = taps[TAPS - i];
        end
        assign others_on[i] = |(gate_on & OTHER_MASK);
        osc_gate_cell #(.STAGES(SYNC_STAGES)) u_gate (
            .clk_src(src_clk[i]), .rst_n(rst_n), .req(req_vec[i]),
            .others_on(others_on[i]), .gate_on(gate_on[i]), .clk_out(clk_part[i]));
    end

    assign sys_clk = |clk_part;

    osc_sw_ctrl #(
        .SEL_W(SEL_W), .NSRC(NSRC), .STABLE_CYC(STABLE_CYC),
        .RST_CODE(RST_CODE), .SYNC_STAGES(SYNC_STAGES)
    ) u_ctrl (
        .ref_clk(ref_clk), .rst_n(rst_n), .sel_in(sel_in),
        .keep_wdt(keep_wdt), .keep_mon(keep_mon), .gate_on(gate_on),
        .req_vec(req_vec), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
        .hf_ready(hf_ready), .lf_ready(lf_ready));

endmodule

// File: rtl/osc_sw_check.sv
`timescale 1ns/1ps
// Module: osc_sw_check
// Property checker for osc_clk_switch, sampled on the reference clock.
// Assumes it is attached with the bind statement at the end of this file.
module osc_sw_check #(
    parameter int NSRC       = 8,
    parameter int STABLE_CYC = 500
) (
    input logic            ref_clk,
    input logic            rst_n,
    input logic            hf_osc_en,
    input logic            hf_ready,
    input logic            lf_ready,
    input logic [NSRC-1:0] gate_vec
);

    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [CW-1:0] on_cnt;

    // Count reference cycles since the fast oscillator was enabled (saturating)
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                           on_cnt <= '0;
        else if (!hf_osc_en)                  on_cnt <= '0;
        else if (on_cnt != CW'(STABLE_CYC))   on_cnt <= on_cnt + 1'b1;
    end

    p_one_gate_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $countones(gate_vec) <= 1);

    p_warm_len_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(hf_ready) |-> (on_cnt >= CW'(STABLE_CYC)));

    p_hf_rise_gate_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(hf_ready) |-> (!gate_vec[0] && (gate_vec != '0)));

    p_lf_rise_gate_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lf_ready) |-> gate_vec[0]);

    p_hf_off_after_lf_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(hf_osc_en) |-> lf_ready);

    p_hf_ready_en_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        hf_ready |-> hf_osc_en);

endmodule

bind osc_clk_switch osc_sw_check #(.NSRC(NSRC), .STABLE_CYC(STABLE_CYC)) u_chk (
    .ref_clk(ref_clk), .rst_n(rst_n), .hf_osc_en(hf_osc_en),
    .hf_ready(hf_ready), .lf_ready(lf_ready), .gate_vec(gate_on));

// File: tb/sim_osc_clk_switch.sv
`timescale 1ns/1ps
// Bench: sweeps every ordered pair of select codes and checks output period,
// enables, ready flags, settling delays, keep-alive handling and held
// selects. Expected periods are computed from the input clock periods.
module sim_osc_clk_switch;

    localparam int  STABLE = 500;
    localparam real HF_PER = 24.0;
    localparam real LF_PER = 820.0;

    logic       ref_clk = 1'b0;
    logic       hf_clk  = 1'b0;
    logic       lf_clk  = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] sel_in  = 3'd6;
    logic       keep_wdt = 1'b0;
    logic       keep_mon = 1'b0;
    logic       sys_clk, hf_osc_en, lf_osc_en, hf_ready, lf_ready;

    osc_clk_switch #(.STABLE_CYC(STABLE)) u0 (
        .ref_clk(ref_clk), .hf_clk(hf_clk), .lf_clk(lf_clk), .rst_n(rst_n),
        .sel_in(sel_in), .keep_wdt(keep_wdt), .keep_mon(keep_mon),
        .sys_clk(sys_clk), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
        .hf_ready(hf_ready), .lf_ready(lf_ready));

    always #5   ref_clk = ~ref_clk;
    always #12  hf_clk  = ~hf_clk;
    always #410 lf_clk  = ~lf_clk;

    int  n_total = 0;
    int  n_fail  = 0;
    int  glitch_n = 0;
    bit  mon_on = 0;
    bit  hold_bad = 0;
    bit  finished = 0;
    realtime t_rise = 0, t_edge = 0, per_last = 0, per_prev = 0;

    // Record the last two rising-edge periods of the output clock
    always @(posedge sys_clk) begin
        per_prev = per_last;
        per_last = $realtime - t_rise;
        t_rise   = $realtime;
    end

    // Count output phases shorter than half a fast-input period
    always @(sys_clk) begin
        if (mon_on && ($realtime - t_edge < HF_PER / 2.0 - 0.1)) glitch_n++;
        t_edge = $realtime;
    end

    function automatic realtime exp_per(input int c);
        return (c == 0) ? LF_PER : HF_PER * real'(1 << (7 - c));
    endfunction

    function automatic realtime rdiff(input realtime a, input realtime b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int lim);
        n_total++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s: got %0d expected >= %0d", tag, act, lim);
        end
    endtask

    task automatic chk_lt(input string tag, input int act, input int lim);
        n_total++;
        if (act >= lim) begin
            n_fail++;
            $display("FAIL %s: got %0d expected < %0d", tag, act, lim);
        end
    endtask

    task automatic set_sel(input int c);
        @(negedge ref_clk);
        sel_in = 3'(c);
    endtask

    // Wait until two consecutive output periods match the code's period
    task automatic settle(input int code, output int cyc, output bit ok);
        realtime e = exp_per(code);
        cyc = 0;
        ok  = 0;
        while (!ok && cyc < 4000) begin
            @(negedge ref_clk);
            cyc++;
            if (!hf_ready) hold_bad = 1;
            if (rdiff(per_last, e) < 0.5 && rdiff(per_prev, e) < 0.5) ok = 1;
        end
    endtask

    task automatic go_code(input int code, input string tag, output int cyc);
        bit ok;
        set_sel(code);
        settle(code, cyc, ok);
        chk_eq({tag, " period ps"}, int'(per_last * 1000.0), int'(exp_per(code) * 1000.0));
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge ref_clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int cyc;
        int cur;
        int n;
        bit ok;

        repeat (20) @(negedge ref_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge ref_clk);
        // R2: reset state
        chk_eq("R2 hf_ready", int'(hf_ready), 1);
        chk_eq("R2 hf_osc_en", int'(hf_osc_en), 1);
        chk_eq("R2 lf_ready", int'(lf_ready), 0);
        chk_eq("R2 lf_osc_en", int'(lf_osc_en), 0);
        settle(6, cyc, ok);
        chk_eq("R2 default rate ok", int'(ok), 1);
        mon_on = 1;
        cur = 6;

        // R1 R4 R5 R6 R7 R8: every ordered pair of codes, keep-alives low
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a == b) continue;
                if (cur != a) go_code(a, "R1 pre", cyc);
                hold_bad = 0;
                go_code(b, "R1 sweep", cyc);
                cur = b;
                repeat (4) @(negedge ref_clk);
                if (b != 0) begin
                    chk_eq("R5 lf_osc_en", int'(lf_osc_en), 0);
                    chk_eq("R5 lf_ready", int'(lf_ready), 0);
                    chk_eq("R5 hf_ready", int'(hf_ready), 1);
                end else begin
                    chk_eq("R7 hf_osc_en", int'(hf_osc_en), 0);
                    chk_eq("R7 hf_ready", int'(hf_ready), 0);
                    chk_eq("R7 lf_ready", int'(lf_ready), 1);
                end
                if (a == 0) chk_ge("R4 settle cycles", cyc, STABLE);
                if (b == 0) chk_ge("R6 settle cycles", cyc, STABLE);
                if (a != 0 && b != 0) begin
                    chk_eq("R8 hf_ready held", int'(hold_bad), 0);
                    chk_eq("R8 hf_osc_en", int'(hf_osc_en), 1);
                    if (a >= 4 && b >= 4) chk_lt("R8 no delay", cyc, STABLE);
                end
            end
        end

        // R4: during the settling wait the output keeps the low-power rate
        if (cur != 0) go_code(0, "R4 pre", cyc);
        set_sel(7);
        repeat (STABLE - 20) @(negedge ref_clk);
        chk_eq("R4 hf_osc_en early", int'(hf_osc_en), 1);
        chk_eq("R4 hf_ready early", int'(hf_ready), 0);
        chk_eq("R4 still low rate ps", int'(per_last * 1000.0), int'(LF_PER * 1000.0));
        n = STABLE - 20;
        while (!hf_ready && n < 4000) begin
            @(negedge ref_clk);
            n++;
        end
        chk_ge("R4 ready delay", n, STABLE);
        settle(7, cyc, ok);
        chk_eq("R4 final rate ok", int'(ok), 1);

        // R10 R6: watchdog keep-alive skips the wait and keeps the flag
        keep_wdt = 1'b1;
        repeat (10) @(negedge ref_clk);
        chk_eq("R10 lf_osc_en wdt", int'(lf_osc_en), 1);
        set_sel(0);
        n = 0;
        while (!lf_ready && n < 4000) begin
            @(negedge ref_clk);
            n++;
        end
        chk_lt("R6 skipped delay wdt", n, STABLE);
        settle(0, cyc, ok);
        chk_eq("R6 low rate ok", int'(ok), 1);
        go_code(5, "R10 fast", cyc);
        repeat (4) @(negedge ref_clk);
        chk_eq("R10 lf_ready kept", int'(lf_ready), 1);
        chk_eq("R10 lf_osc_en kept", int'(lf_osc_en), 1);
        keep_wdt = 1'b0;
        repeat (10) @(negedge ref_clk);
        chk_eq("R10 lf_osc_en dropped", int'(lf_osc_en), 0);
        chk_eq("R10 lf_ready dropped", int'(lf_ready), 0);

        // R10 R6: fail-safe monitor keep-alive alone
        keep_mon = 1'b1;
        repeat (10) @(negedge ref_clk);
        chk_eq("R10 lf_osc_en mon", int'(lf_osc_en), 1);
        set_sel(0);
        n = 0;
        while (!lf_ready && n < 4000) begin
            @(negedge ref_clk);
            n++;
        end
        chk_lt("R6 skipped delay mon", n, STABLE);
        settle(0, cyc, ok);
        keep_mon = 1'b0;
        go_code(5, "R9 pre", cyc);

        // R9: select changes during a handover are held and applied later
        set_sel(0);
        repeat (100) @(negedge ref_clk);
        set_sel(2);
        settle(2, cyc, ok);
        chk_eq("R9 held select ok", int'(ok), 1);
        set_sel(1);
        repeat (3) @(negedge ref_clk);
        set_sel(4);
        settle(4, cyc, ok);
        chk_eq("R9 fast held ok", int'(ok), 1);
        repeat (4) @(negedge ref_clk);
        chk_eq("R9 hf_ready", int'(hf_ready), 1);

        // R3: no short phase was seen on the output
        chk_eq("R3 short phases", glitch_n, 0);
        finish_run();
    end

endmodule